// File: doc/BRIEF.md
# Five-Level Multicarrier PWM Modulator

This block turns a signed reference sample into a five-level switching command for one leg of a modular multilevel converter. A single phase counter, advanced by a carrier-step enable, produces four triangular carriers. The reference is compared with each carrier, and the four comparison bits are decoded into a level from -2 to +2. Here +2 stands for the positive half of the DC link, +1 for a quarter of it, 0 for the midpoint, and -1 and -2 for the matching negative values.

A two-bit layout input picks the carrier arrangement at run time. Three of the layouts stack four quarter-range carriers into bands, and they differ only in which bands run inverted. The fourth layout spreads four full-range carriers a quarter period apart. A new layout is taken only at the peak of the shared triangle, so a carrier never switches over in the middle of a ramp. With a carrier step rate giving 23 carrier periods per reference period (1150 Hz against 50 Hz), the block serves as the modulator stage between a reference generator and the dead-time and gate-drive logic.

Top module: `mcpwm5_mod`

## Requirements
- R1: While rst_n is low, level reads 0 and cmp_bits reads 4'b0011. Reset clears the phase counter to 0, which is the carrier minimum, counting upward, and makes layout 0 the active layout.
- R2: The phase counter p has REF_W-1 bits. It advances by one, wrapping, only on a clock where step_en is high. With step_en low the carriers hold still, so a constant reference gives constant outputs. With Q = 2^(REF_W-2), the base triangle is t = p when p < Q and t = 2Q-1-p otherwise.
- R3: The reference is signed two's complement. It is compared as u = ref_smp + 2^(REF_W-1), and bit k of cmp_bits is 1 exactly when u is strictly greater than carrier k. Carriers are in the same offset scale, from 0 to 4Q-1.
- R4: Layout code 0 (in-phase bands) sets carrier k to k*Q + t for k = 0..3.
- R5: Layout code 1 (halves opposed) sets carriers 0 and 1 to k*Q + (Q-1-t) and carriers 2 and 3 to k*Q + t.
- R6: Layout code 2 (alternating bands) sets carriers 1 and 3 to k*Q + (Q-1-t) and carriers 0 and 2 to k*Q + t.
- R7: Layout code 3 (shifted carriers) sets carrier k to 4*t_k. Here t_k is the base triangle taken at phase (p + k*Q/2) mod 2Q, which is a quarter period per carrier.
- R8: In layout codes 0 to 2, level is k-1 for the highest bit k set in cmp_bits, and -2 when no bit is set. The result is +2 only when the reference is above every carrier.
- R9: In layout code 3, level equals the number of set bits in cmp_bits minus 2.
- R10: A new value on layout_sel becomes the active layout only on a step that moves p from Q-1 to Q, the peak of the shared triangle. At all other times the previous layout stays in force.
- R11: cmp_bits and level are registered. Their values after a rising edge come from the phase, the active layout and ref_smp as they stood just before that edge. level is 3-bit two's complement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Advances the carrier phase by one step |
| layout_sel | input | 2 | Requested carrier layout (0 in-phase, 1 halves opposed, 2 alternating, 3 shifted) |
| ref_smp | input | REF_W | Signed reference sample |
| cmp_bits | output | 4 | Registered comparison of the reference against carriers 0..3 |
| level | output | 3 | Registered signed output level, -2 to +2 |

## Verification
The checker assumes that rst_n is driven low before the first clock edge and is released once without being pulsed again, because its phase-step and layout-latch properties look one cycle back. It also assumes that step_en and layout_sel are settled at each rising edge, and that ref_smp may take any value in its range. The bench meets these assumptions by changing every input on the falling edge and by holding reset low for several cycles at the start only. Its random references cover the whole signed range. Directed runs add the extreme codes, a long frozen stretch with no steps, and layout requests made away from the peak.

// File: rtl/mcpwm5_pkg.sv
package mcpwm5_pkg;

   // Carrier arrangement codes as seen on layout_sel
   typedef enum logic [1:0] {
      LAYOUT_SAME  = 2'd0,
      LAYOUT_SPLIT = 2'd1,
      LAYOUT_ALT   = 2'd2,
      LAYOUT_SHIFT = 2'd3
   } layout_e;

   localparam int unsigned NUM_CARRIERS = 4;

   typedef logic signed [2:0] level_t;

endpackage

// File: rtl/mcpwm5_phase.sv
module mcpwm5_phase
   import mcpwm5_pkg::*;
#(
   parameter int unsigned P_W = 11
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           step_en,
   input  layout_e        layout_in,
   output logic [P_W-1:0] phase_q,
   output layout_e        layout_q
);

   // Last phase value of the rising ramp: the following step sits on the peak
   localparam logic [P_W-1:0] PEAK = {1'b0, {(P_W-1){1'b1}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= '0;
         layout_q <= LAYOUT_SAME;
      end else if (step_en) begin
         phase_q <= phase_q + P_W'(1);
         if (phase_q == PEAK) begin
            layout_q <= layout_in;
         end
      end
   end

endmodule

// File: rtl/mcpwm5_carrier.sv
module mcpwm5_carrier
   import mcpwm5_pkg::*;
#(
   parameter int unsigned REF_W = 12,
   parameter int unsigned IDX   = 0
) (
   input  logic [REF_W-2:0] phase,
   input  layout_e          layout,
   output logic [REF_W-1:0] carrier_u
);

   localparam int unsigned TRI_W = REF_W - 2;
   localparam int unsigned P_W   = REF_W - 1;
   localparam logic [1:0]  BAND  = 2'(IDX);
   // Quarter of the carrier period for the shifted layout
   localparam logic [P_W-1:0] PS_OFS = P_W'(IDX * (2 ** (TRI_W - 1)));
   // Band inversion patterns for the opposed layouts
   localparam bit INV_SPLIT = (IDX < 2);
   localparam bit INV_ALT   = ((IDX % 2) == 1);

   function automatic logic [TRI_W-1:0] fold(input logic [P_W-1:0] p);
      return p[TRI_W] ? ~p[TRI_W-1:0] : p[TRI_W-1:0];
   endfunction

   logic [TRI_W-1:0] ramp_ls;
   logic [TRI_W-1:0] ramp_ps;
   logic             inv;

   always_comb begin
      ramp_ls = fold(phase);
      ramp_ps = fold(phase + PS_OFS);
      unique case (layout)
         LAYOUT_SPLIT: inv = INV_SPLIT;
         LAYOUT_ALT:   inv = INV_ALT;
         default:      inv = 1'b0;
      endcase
      if (layout == LAYOUT_SHIFT) begin
         carrier_u = {ramp_ps, 2'b00};
      end else begin
         carrier_u = {BAND, (inv ? ~ramp_ls : ramp_ls)};
      end
   end

endmodule

// File: rtl/mcpwm5_decode.sv
module mcpwm5_decode
   import mcpwm5_pkg::*;
(
   input  logic [NUM_CARRIERS-1:0] cmp,
   input  layout_e                 layout,
   output level_t                  level
);

   always_comb begin
      if (layout == LAYOUT_SHIFT) begin
         // Shifted carriers: count of carriers exceeded, re-centred on zero
         level = level_t'(int'($countones(cmp)) - 2);
      end else begin
         // Stacked bands: the highest band passed sets the level
         casez (cmp)
            4'b1???: level = level_t'(2);
            4'b01??: level = level_t'(1);
            4'b001?: level = level_t'(0);
            4'b0001: level = level_t'(-1);
            default: level = level_t'(-2);
         endcase
      end
   end

endmodule

// File: rtl/mcpwm5_mod.sv
module mcpwm5_mod
   import mcpwm5_pkg::*;
#(
   parameter int unsigned REF_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_en,
   input  logic [1:0]        layout_sel,
   input  logic [REF_W-1:0]  ref_smp,
   output logic [3:0]        cmp_bits,
   output logic signed [2:0] level
);

   localparam int unsigned P_W = REF_W - 1;
   localparam int unsigned NC  = NUM_CARRIERS;

   if (REF_W < 5) begin : g_width_check
      $error("mcpwm5_mod: REF_W must be at least 5");
   end

   // Offset-binary view of the signed reference
   logic [REF_W-1:0] ref_u;
   assign ref_u = {~ref_smp[REF_W-1], ref_smp[REF_W-2:0]};

   logic [P_W-1:0] phase_q;
   layout_e        layout_q;

   mcpwm5_phase #(.P_W(P_W)) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .step_en  (step_en),
      .layout_in(layout_e'(layout_sel)),
      .phase_q  (phase_q),
      .layout_q (layout_q)
   );

   logic [NC-1:0] cmp_c;
   level_t        level_c;

   for (genvar k = 0; k < NC; k++) begin : g_car
      logic [REF_W-1:0] car_u;
      mcpwm5_carrier #(.REF_W(REF_W), .IDX(k)) u_car (
         .phase    (phase_q),
         .layout   (layout_q),
         .carrier_u(car_u)
      );
      assign cmp_c[k] = (ref_u > car_u);
   end

   mcpwm5_decode u_dec (
      .cmp   (cmp_c),
      .layout(layout_q),
      .level (level_c)
   );

   logic [NC-1:0] cmp_q;
   level_t        level_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q   <= NC'(3);
         level_q <= '0;
      end else begin
         cmp_q   <= cmp_c;
         level_q <= level_c;
      end
   end

   assign cmp_bits = cmp_q;
   assign level    = level_q;

endmodule

// File: rtl/mcpwm5_checker.sv
module mcpwm5_checker #(
   parameter int unsigned REF_W = 12
) (
   input logic               clk,
   input logic               rst_n,
   input logic               step_en,
   input logic [REF_W-2:0]   phase_q,
   input logic [1:0]         layout_q,
   input logic [3:0]         cmp_q,
   input logic signed [2:0]  level_q
);

   localparam int unsigned P_W = REF_W - 1;
   localparam logic [P_W-1:0] PEAK = {1'b0, {(P_W-1){1'b1}}};

   // R1: outputs sit at the midpoint level while reset is held
   assert_reset_out_R1: assert property (@(posedge clk)
      !rst_n |=> (level_q == 3'sd0 && cmp_q == 4'b0011));

   // R2: no step, no phase movement
   assert_phase_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !step_en |=> (phase_q == $past(phase_q)));

   // R2: each step moves the phase by exactly one
   assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      step_en |=> (phase_q == $past(phase_q) + P_W'(1)));

   // R10: the active layout changes only on the peak step
   assert_layout_peak_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (layout_q != $past(layout_q)) |-> ($past(step_en) && $past(phase_q) == PEAK));

   // R8: stacked bands give a thermometer pattern
   assert_thermo_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(layout_q) != 2'd3) |->
         (cmp_q == 4'b0000 || cmp_q == 4'b0001 || cmp_q == 4'b0011 ||
          cmp_q == 4'b0111 || cmp_q == 4'b1111));

   // R9: level tracks the count of carriers exceeded
   assert_level_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(cmp_q) == int'(level_q) + 2));

endmodule

bind mcpwm5_mod mcpwm5_checker #(.REF_W(REF_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .step_en (step_en),
   .phase_q (phase_q),
   .layout_q(layout_q),
   .cmp_q   (cmp_q),
   .level_q (level_q)
);

// File: tb/test_mcpwm5_mod.sv
`timescale 1ns/1ps
module test_mcpwm5_mod;

   localparam int REF_W = 12;
   localparam int Q     = 2 ** (REF_W - 2);
   localparam int H     = 2 ** (REF_W - 1);
   localparam int WD_CYCLES = 150000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              step_en = 1'b0;
   logic [1:0]        layout_sel = 2'd0;
   logic [REF_W-1:0]  ref_smp = '0;
   logic [3:0]        cmp_bits;
   logic signed [2:0] level;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   int ph_m  = 0;
   int lay_m = 0;

   always #2.5 clk = ~clk;

   mcpwm5_mod #(.REF_W(REF_W)) i_mcpwm5_mod (
      .clk       (clk),
      .rst_n     (rst_n),
      .step_en   (step_en),
      .layout_sel(layout_sel),
      .ref_smp   (ref_smp),
      .cmp_bits  (cmp_bits),
      .level     (level)
   );

   function automatic int fold_m(int p);
      int pp = p % (2 * Q);
      return (pp >= Q) ? (2 * Q - 1 - pp) : pp;
   endfunction

   function automatic int carrier_m(int lay, int k, int ph);
      int t;
      bit inv;
      if (lay == 3) return 4 * fold_m(ph + k * (Q / 2));
      t   = fold_m(ph);
      inv = (lay == 1 && k < 2) || (lay == 2 && (k % 2) == 1);
      return k * Q + (inv ? (Q - 1 - t) : t);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  Result: errors=%0d of %0d checks", errors, checks);
   endtask

   // One clock: drive at the falling edge, model at the rising edge, compare at the next falling edge
   task automatic cyc(input bit st, input int md, input int rf, input string ctx);
      int  exp_cmp, cnt, top, exp_lvl, lay_used;
      string rc, rl;
      step_en    = st;
      layout_sel = md[1:0];
      ref_smp    = rf[REF_W-1:0];
      @(posedge clk);
      lay_used = lay_m;
      exp_cmp = 0; cnt = 0; top = -1;
      for (int k = 0; k < 4; k++) begin
         if (rf + H > carrier_m(lay_used, k, ph_m)) begin
            exp_cmp |= (1 << k);
            cnt++;
            top = k;
         end
      end
      exp_lvl = (lay_used == 3) ? cnt - 2 : ((top < 0) ? -2 : top - 1);
      if (st) begin
         if (ph_m == Q - 1) lay_m = md;
         ph_m = (ph_m + 1) % (2 * Q);
      end
      @(negedge clk);
      case (lay_used)
         0: rc = "R4";
         1: rc = "R5";
         2: rc = "R6";
         default: rc = "R7";
      endcase
      rl = (lay_used == 3) ? "R9" : "R8";
      check(int'(cmp_bits) == exp_cmp, {rc, " R3 cmp_bits ", ctx}, int'(cmp_bits), exp_cmp);
      check(int'(level) == exp_lvl, {rl, " R11 level ", ctx}, int'(level), exp_lvl);
   endtask

   initial begin
      void'($urandom(32'd4242));
      // R1: reset state
      repeat (4) @(negedge clk);
      check(int'(level) == 0, "R1 reset level", int'(level), 0);
      check(cmp_bits == 4'b0011, "R1 reset cmp_bits", int'(cmp_bits), 3);
      rst_n = 1'b1;
      ph_m  = 0;
      lay_m = 0;

      // R3: extreme reference codes
      for (int i = 0; i < 20; i++) cyc(1'b1, 0, -H, "R3 floor");
      for (int i = 0; i < 20; i++) cyc(1'b1, 0, H - 1, "R3 ceiling");
      for (int i = 0; i < 10; i++) cyc(1'b1, 0, 0, "R3 zero");

      // R2: no steps, carriers frozen
      for (int i = 0; i < 40; i++) cyc(1'b0, 0, Q / 3, "R2 frozen");

      // R10: request shifted layout just before the peak
      while (ph_m != Q - 3) cyc(1'b1, 0, 5, "R10 approach");
      for (int i = 0; i < 8; i++) cyc(1'b1, 3, 5, "R10 switch");
      // R10: a request away from the peak is held off
      for (int i = 0; i < 30; i++) cyc(1'b1, 1, -17, "R10 held off");

      // Random segments in each layout
      for (int seg = 0; seg < 8; seg++) begin
         for (int i = 0; i < 3000; i++) begin
            int rf;
            bit st;
            st = (($urandom % 8) != 0);
            rf = int'($urandom % (2 * H)) - H;
            cyc(st, seg % 4, rf, "random");
         end
      end

      // R7: shifted layout with small references around zero
      for (int i = 0; i < 3000; i++) begin
         int rf;
         rf = int'($urandom % 64) - 32;
         cyc(1'b1, 3, rf, "R7 near zero");
      end

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R11 watchdog actual=%0d expected=%0d", 0, 1);
         summary();
         $finish;
      end
   end

endmodule